// File: doc/BRIEF.md
# Supply Supervisor with Capacitor-Presence Test

This block is the digital supervisor that combines three supply comparator flags into one device reset. It watches the external supply flag and the flags of two internal regulators, one feeding the analog section and one feeding the digital logic. Each flag is active high for "good". The block holds the device in reset from power-on until all three flags read good. After that, it asserts reset whenever any flag stays low longer than the fault delay set for that flag. Each flag has its own delay.

While the device runs, the block also pulses a regulator-off strobe at a fixed period. The strobe turns off both regulators at the same time, for a few cycles. If a regulator's external filter capacitor is missing, that regulator falls below its threshold during the pulse. Its flag then drops and the normal undervoltage path resets the device.

The control is a four-state machine:
- ST_POR is the power-on wait.
- ST_HOLD is the minimum-hold count after all flags recover.
- ST_RUN is the only state in which reset is released.
- ST_TRIP is the state after a filtered fault.

The transitions are:
- ST_POR to ST_HOLD when all synchronized flags are good.
- ST_TRIP to ST_HOLD when all synchronized flags are good.
- ST_HOLD back to ST_TRIP when any synchronized flag goes low.
- ST_HOLD to ST_RUN once the hold count expires.
- ST_RUN to ST_TRIP when any filtered fault is present.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards until all three flags have been good through the synchronizer, `dev_reset_o` is 1. Reset is not released while any flag is low.
- R2: Suppose `ext_ok_i` is low at EXT_DLY or more consecutive rising edges while in run. Then `dev_reset_o` rises after the (EXT_DLY+3)-th edge, counting from the first edge that sees the low level. The three extra edges are two for the synchronizer and one for the state register.
- R3: `dreg_ok_i` low for DREG_DLY or more consecutive edges asserts reset after edge DREG_DLY+3, using its own delay.
- R4: `areg_ok_i` low for AREG_DLY or more consecutive edges asserts reset after edge AREG_DLY+3, independently of the other regulator.
- R5: A flag that returns good before reaching its delay clears its counter, and no reset is issued.
- R6: Reset is released exactly HOLD_CYC+3 edges after the first edge that sees the last flag good. After a trip with a low run of L edges, release is at edge max(L+3, D+4)+HOLD_CYC, counted from the first low edge, where D is the flag's delay.
- R7: In run, `reg_off_o` is 1 for TEST_WIDTH cycles. It rises PERIOD−TEST_WIDTH edges after the edge that releases reset, and then repeats every PERIOD edges.
- R8: `reg_off_o` is 0 whenever `dev_reset_o` is 1. The pulse timer restarts from zero at each release.
- R9: A regulator flag that drops during a test pulse and stays low for its delay causes a full reset, with the same timing as R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_ok_i | input | 1 | External supply comparator, 1 = good |
| dreg_ok_i | input | 1 | Digital regulator comparator, 1 = good |
| areg_ok_i | input | 1 | Analog regulator comparator, 1 = good |
| dev_reset_o | output | 1 | Device reset, active high |
| reg_off_o | output | 1 | Regulator-disable strobe for the capacitor test |

## Verification
Suppose a filter counter sticks or clears at the wrong time. Then reset rises one or more edges off the predicted edge, or it rises after a glitch shorter than the delay. The bench compares against the exact edge, so both errors show within a few cycles. A wrong hold count or a wrong state transition moves the release edge. A timer that fails to restart moves the first test pulse after release, which shows within one period. Random fault lengths around each delay exercise both sides of every threshold.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2,
        ST_TRIP = 2'd3
    } supv_state_e;

    localparam int N_FLAGS = 3;
    localparam int IDX_EXT  = 0;
    localparam int IDX_DREG = 1;
    localparam int IDX_AREG = 2;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Both stages reset to "bad" so that nothing reads good before the flags are sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/supv_fault_filter.sv
module supv_fault_filter #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    output logic fault_o
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt_q;

    // Count consecutive low cycles. Stop at the limit. Clear as soon as the flag is good.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ok_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fault_o = (cnt_q == LIMIT);

    // R5: a fault can only appear after a low flag was seen.
    assert_fault_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(!ok_i));
endmodule

// File: rtl/supv_captest_timer.sv
module supv_captest_timer #(
    parameter int PERIOD = 1000,
    parameter int WIDTH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic pulse_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] START = CW'(PERIOD - WIDTH);

    logic [CW-1:0] cnt_q;

    // The count is held at zero while disabled, so every enable starts a fresh period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The pulse occupies the tail of each period.
    assign pulse_o = en_i && (cnt_q >= START);

    // Checker: length of the current run of high pulse cycles.
    logic [CW-1:0] chk_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_run_q <= '0;
        else        chk_run_q <= pulse_o ? chk_run_q + 1'b1 : '0;
    end

    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (chk_run_q < CW'(WIDTH)));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int EXT_DLY     = 64,
    parameter int DREG_DLY    = 16,
    parameter int AREG_DLY    = 16,
    parameter int HOLD_CYC    = 256,
    parameter int TEST_PERIOD = 100000,
    parameter int TEST_WIDTH  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ok_i,
    input  logic dreg_ok_i,
    input  logic areg_ok_i,
    output logic dev_reset_o,
    output logic reg_off_o
);
    import supv_pkg::*;

    localparam int HCW = $clog2(HOLD_CYC + 1);
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

    logic [N_FLAGS-1:0] raw_ok;
    logic [N_FLAGS-1:0] ok_s;
    logic [N_FLAGS-1:0] fault;
    logic               all_ok;
    logic               any_fault;
    logic               tmr_en;

    supv_state_e state_q, state_d;
    logic [HCW-1:0] hold_q;

    assign raw_ok[IDX_EXT]  = ext_ok_i;
    assign raw_ok[IDX_DREG] = dreg_ok_i;
    assign raw_ok[IDX_AREG] = areg_ok_i;

    supv_sync #(.W(N_FLAGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_ok),
        .q_o   (ok_s)
    );

    // One filter per flag. Each flag gets its own delay length.
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flt
        localparam int DLY = (g == IDX_EXT)  ? EXT_DLY :
                             (g == IDX_DREG) ? DREG_DLY : AREG_DLY;
        supv_fault_filter #(.DLY(DLY)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .ok_i    (ok_s[g]),
            .fault_o (fault[g])
        );
    end

    assign all_ok    = &ok_s;
    assign any_fault = |fault;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POR;
        else        state_q <= state_d;
    end

    // Hold counter: runs only in ST_HOLD.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hold_q <= '0;
        else if (state_q == ST_HOLD) hold_q <= hold_q + 1'b1;
        else                        hold_q <= '0;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:  if (all_ok) state_d = ST_HOLD;
            ST_HOLD: begin
                if (!all_ok)                state_d = ST_TRIP;
                else if (hold_q == HOLD_LAST) state_d = ST_RUN;
            end
            ST_RUN:  if (any_fault) state_d = ST_TRIP;
            ST_TRIP: if (all_ok) state_d = ST_HOLD;
            default: state_d = ST_POR;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        dev_reset_o = 1'b1;
        tmr_en      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                dev_reset_o = 1'b0;
                tmr_en      = 1'b1;
            end
            ST_POR, ST_HOLD, ST_TRIP: begin
                dev_reset_o = 1'b1;
                tmr_en      = 1'b0;
            end
            default: begin
                dev_reset_o = 1'b1;
                tmr_en      = 1'b0;
            end
        endcase
    end

    supv_captest_timer #(.PERIOD(TEST_PERIOD), .WIDTH(TEST_WIDTH)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (tmr_en),
        .pulse_o (reg_off_o)
    );

    assert_no_release_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !all_ok) |=> dev_reset_o);
    assert_ext_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fault[IDX_EXT]) |=> dev_reset_o);
    assert_dreg_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fault[IDX_DREG]) |=> dev_reset_o);
    assert_areg_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fault[IDX_AREG]) |=> dev_reset_o);
    assert_release_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_reset_o) |-> $past(all_ok));
    assert_no_pulse_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |-> !reg_off_o);
endmodule

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;
    localparam int EXT_D  = 6;
    localparam int DREG_D = 4;
    localparam int AREG_D = 5;
    localparam int HOLD   = 8;
    localparam int PER    = 40;
    localparam int WID    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_ok = 1'b0, dreg_ok = 1'b0, areg_ok = 1'b0;
    logic dev_reset, reg_off;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    supply_supervisor #(
        .EXT_DLY(EXT_D), .DREG_DLY(DREG_D), .AREG_DLY(AREG_D),
        .HOLD_CYC(HOLD), .TEST_PERIOD(PER), .TEST_WIDTH(WID)
    ) u_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .ext_ok_i(ext_ok), .dreg_ok_i(dreg_ok),
        .areg_ok_i(areg_ok), .dev_reset_o(dev_reset), .reg_off_o(reg_off)
    );

    function automatic bit exp_trip(int len, int dly);
        return len >= dly;
    endfunction

    // Release edge, counted from the first edge that sees the flag low.
    function automatic int exp_release(int len, int dly);
        int a = len + 3;
        int b = dly + 4;
        return ((a > b) ? a : b) + HOLD;
    endfunction

    function automatic int dly_of(int sel);
        return (sel == 0) ? EXT_D : (sel == 1) ? DREG_D : AREG_D;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic set_flag(input int sel, input logic v);
        case (sel)
            0: ext_ok = v;
            1: dreg_ok = v;
            default: areg_ok = v;
        endcase
    endtask

    // Call with the current sample just after the edge that released reset.
    task automatic chk_pulses_after_release(input string tag);
        for (int c = 1; c <= PER; c++) begin
            step();
            if (c == PER - WID - 1) chk(reg_off, 1'b0, {tag, " R8 timer restart"});
            if (c == PER - WID)     chk(reg_off, 1'b1, {tag, " R7 pulse start"});
            if (c == PER - 1)       chk(reg_off, 1'b1, {tag, " R7 pulse end"});
            if (c == PER)           chk(reg_off, 1'b0, {tag, " R7 pulse over"});
        end
    endtask

    task automatic cap_test(input int sel, input string tag);
        int d = dly_of(sel);
        int guard = 0;
        while (!reg_off && guard < 4 * PER) begin
            step();
            guard++;
        end
        chk(reg_off, 1'b1, {tag, " R7 pulse seen"});
        set_flag(sel, 1'b0);
        for (int c = 1; c <= d + 3; c++) begin
            step();
            if (c == d + 2) chk(dev_reset, 1'b0, {tag, " R9 before delay"});
        end
        chk(dev_reset, 1'b1, {tag, " R9 reset from cap test"});
        chk(reg_off, 1'b0, {tag, " R8 no pulse in reset"});
        set_flag(sel, 1'b1);
        guard = 0;
        while (dev_reset && guard < 100) begin
            step();
            guard++;
        end
        chk(dev_reset, 1'b0, {tag, " R6 recovered"});
        chk_pulses_after_release(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7719));
        step();
        chk(dev_reset, 1'b1, "R1 reset during rst_n");
        chk(reg_off, 1'b0, "R8 no pulse during rst_n");
        rst_n = 1'b1;
        repeat (20) step();
        chk(dev_reset, 1'b1, "R1 all flags bad");
        ext_ok = 1'b1;
        dreg_ok = 1'b1;
        repeat (20) step();
        chk(dev_reset, 1'b1, "R1 analog flag still bad");
        chk(reg_off, 1'b0, "R8 no pulse before release");
        areg_ok = 1'b1;
        for (int c = 1; c <= HOLD + 3; c++) begin
            step();
            if (c == HOLD + 2) chk(dev_reset, 1'b1, "R6 hold not done");
        end
        chk(dev_reset, 1'b0, "R1 R6 power-on release");
        chk_pulses_after_release("por");
        repeat (PER - WID) step();
        chk(reg_off, 1'b1, "R7 second period");

        cap_test(1, "dreg");
        cap_test(2, "areg");

        for (int it = 0; it < 60; it++) begin
            int sel = $urandom_range(0, 2);
            int d = dly_of(sel);
            int len = $urandom_range(1, 2 * d);
            bit trip = exp_trip(len, d);
            int rel = exp_release(len, d);
            int last = trip ? rel : d + 3;
            string req = (sel == 0) ? "R2" : (sel == 1) ? "R3" : "R4";
            set_flag(sel, 1'b0);
            for (int c = 1; c <= last; c++) begin
                step();
                if (c == len) set_flag(sel, 1'b1);
                if (c == d + 2) chk(dev_reset, 1'b0, {req, " before delay"});
                if (c == d + 3) chk(dev_reset, trip, trip ? {req, " trip"} : "R5 glitch ignored");
                if (trip && c == d + 3) chk(reg_off, 1'b0, "R8 no pulse in reset");
                if (trip && c == rel - 1) chk(dev_reset, 1'b1, "R6 still held");
                if (trip && c == rel) chk(dev_reset, 1'b0, "R6 release edge");
            end
            if (trip && (it % 6 == 0)) chk_pulses_after_release("rand");
            repeat (3) step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule